// File: doc/BRIEF.md
# Gated Timebase Match Comparator

This block watches a free-running timebase and compares it with the match value of two channel comparators, A and B. When a comparator finds a hit while its recognition window is open, it sets a sticky match flag and pulses an event strobe for one clock. Comparisons are made only on clocks where the microcycle enable tick is high.

Each comparator has its own match value, its own comparison mode and its own 3-bit pin-action configuration. Both share a thread match-enable flag and a one-microcycle disable pulse driven by the context-switch sequencer. If bit 2 of a comparator's configuration is clear, the comparator is blind whenever the enable flag is low or the disable pulse is high. If bit 2 is set, recognition is always open for that comparator.

In equal-only mode, a timebase value that matches only while the window is closed is lost. In greater-or-equal mode, the hit is taken late on the first open tick where the timebase is still at or above the match value. The flag stays set until the comparator's clear input is driven.

Top module: `match_gate_cmp`

## Requirements
- R1: While reset is high, and on the first clock after it, both match flags and both strobes are 0.
- R2: Mode 0 is equal-only. An open tick with timebase equal to the match value sets the flag after that clock edge and drives the strobe high for exactly that one clock.
- R3: Mode 1 is greater-or-equal. It treats both values as unsigned, and an open tick with timebase >= match value sets the flag. A timebase below the match value never sets it.
- R4: On a clock with the tick input low, a flag that is clear stays clear, whatever the other inputs are.
- R5: With configuration bit 2 clear, a low match-enable flag blocks recognition on every tick where it is low.
- R6: With configuration bit 2 clear, a high disable pulse blocks recognition on that tick, even when the match-enable flag is high.
- R7: With configuration bit 2 set, the match-enable flag, the disable pulse and configuration bits 1:0 have no effect, and recognition is always open.
- R8: In equal-only mode, a match that exists only on blocked ticks is lost. It is not recognized once the window reopens with the timebase past the match value.
- R9: In greater-or-equal mode, a match passed while blocked is recognized on the first open tick where the timebase is still >= the match value.
- R10: A set flag stays set until its clear input is high. While it is set, no further strobe is produced.
- R11: A clear input on a clock edge leaves the flag 0 after that edge, even if a hit is recognized on the same tick. No strobe is produced on that clock.
- R12: The A and B comparators are independent: a hit, clear, mode or configuration on one does not change the flag or strobe of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Microcycle enable; comparisons happen only when high |
| timebase | input | TBW | Free-running timebase value |
| thread_me | input | 1 | Match-enable flag of the running thread |
| tst_dis | input | 1 | One-microcycle disable pulse from the context-switch sequencer |
| match_a | input | TBW | Match value of comparator A |
| mode_a | input | 1 | Comparator A mode: 0 equal-only, 1 greater-or-equal |
| pin_cfg_a | input | 3 | Comparator A pin-action configuration; bit 2 forces recognition open |
| clr_a | input | 1 | Clears the flag of comparator A |
| match_b | input | TBW | Match value of comparator B |
| mode_b | input | 1 | Comparator B mode: 0 equal-only, 1 greater-or-equal |
| pin_cfg_b | input | 3 | Comparator B pin-action configuration; bit 2 forces recognition open |
| clr_b | input | 1 | Clears the flag of comparator B |
| flag_a | output | 1 | Sticky match flag of comparator A |
| strobe_a | output | 1 | One-clock event pulse when flag A is set |
| flag_b | output | 1 | Sticky match flag of comparator B |
| strobe_b | output | 1 | One-clock event pulse when flag B is set |

## Verification
Directed sequences take one comparator through a hit that falls on a blocked tick and then move the timebase past the match value. This separates the equal-only loss from the greater-or-equal late hit. Further directed cases set configuration bit 2 under a low enable and a high disable pulse to show the override, and place a clear on the same tick as a hit to show that the clear takes priority. Constrained-random cycles then hold the timebase close to the match values and randomise the tick, the gating inputs, the clears, the modes and the configurations on both comparators. This exposes any crosstalk between A and B, any evaluation off the tick, and any extra strobe while a flag is held.

// File: rtl/mgc_pkg.sv
package mgc_pkg;

    typedef enum logic {
        CMP_EQ = 1'b0,
        CMP_GE = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        cmp_mode_e  mode;
        logic [2:0] pin_cfg;
        logic       clr;
    } chan_ctl_t;

    typedef struct packed {
        logic flag;
        logic strobe;
    } chan_out_t;

    localparam int unsigned NUM_CHAN    = 2;
    localparam int unsigned CFG_OVR_BIT = 2;

    function automatic logic window_open(input logic [2:0] cfg,
                                         input logic       me,
                                         input logic       dis);
        return cfg[CFG_OVR_BIT] | (me & ~dis);
    endfunction

endpackage

// File: rtl/mgc_gate.sv
module mgc_gate
    import mgc_pkg::*;
(
    input  logic [2:0] pin_cfg,
    input  logic       thread_me,
    input  logic       tst_dis,
    output logic       open
);
    always_comb begin
        open = window_open(pin_cfg, thread_me, tst_dis);
    end
endmodule

// File: rtl/mgc_compare.sv
module mgc_compare
    import mgc_pkg::*;
#(
    parameter int unsigned TBW = 24
) (
    input  logic [TBW-1:0] timebase,
    input  logic [TBW-1:0] match_val,
    input  cmp_mode_e      mode,
    output logic           hit
);
    logic eq_hit;
    logic ge_hit;

    always_comb begin
        eq_hit = (timebase == match_val);
        ge_hit = (timebase >= match_val);
        unique case (mode)
            CMP_EQ:  hit = eq_hit;
            CMP_GE:  hit = ge_hit;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mgc_flag.sv
module mgc_flag
    import mgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      open,
    input  logic      hit,
    input  logic      clr,
    output chan_out_t out
);
    logic flag_q;
    logic strobe_q;
    logic recog;

    always_comb begin
        recog = tick & open & hit & ~flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else if (clr) begin
            flag_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            flag_q   <= flag_q | recog;
            strobe_q <= recog;
        end
    end

    always_comb begin
        out.flag   = flag_q;
        out.strobe = strobe_q;
    end
endmodule

// File: rtl/match_gate_cmp.sv
module match_gate_cmp
    import mgc_pkg::*;
#(
    parameter int unsigned TBW = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [TBW-1:0] timebase,
    input  logic           thread_me,
    input  logic           tst_dis,
    input  logic [TBW-1:0] match_a,
    input  logic           mode_a,
    input  logic [2:0]     pin_cfg_a,
    input  logic           clr_a,
    input  logic [TBW-1:0] match_b,
    input  logic           mode_b,
    input  logic [2:0]     pin_cfg_b,
    input  logic           clr_b,
    output logic           flag_a,
    output logic           strobe_a,
    output logic           flag_b,
    output logic           strobe_b
);
    chan_ctl_t          ctl  [NUM_CHAN];
    logic [TBW-1:0]     mval [NUM_CHAN];
    chan_out_t          res  [NUM_CHAN];

    always_comb begin
        ctl[0].mode    = cmp_mode_e'(mode_a);
        ctl[0].pin_cfg = pin_cfg_a;
        ctl[0].clr     = clr_a;
        ctl[1].mode    = cmp_mode_e'(mode_b);
        ctl[1].pin_cfg = pin_cfg_b;
        ctl[1].clr     = clr_b;
        mval[0]        = match_a;
        mval[1]        = match_b;
    end

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        logic open;
        logic hit;

        mgc_gate u_gate (
            .pin_cfg   (ctl[ch].pin_cfg),
            .thread_me (thread_me),
            .tst_dis   (tst_dis),
            .open      (open)
        );

        mgc_compare #(.TBW(TBW)) u_cmp (
            .timebase  (timebase),
            .match_val (mval[ch]),
            .mode      (ctl[ch].mode),
            .hit       (hit)
        );

        mgc_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .open (open),
            .hit  (hit),
            .clr  (ctl[ch].clr),
            .out  (res[ch])
        );
    end

    always_comb begin
        flag_a   = res[0].flag;
        strobe_a = res[0].strobe;
        flag_b   = res[1].flag;
        strobe_b = res[1].strobe;
    end
endmodule

// File: rtl/mgc_checker.sv
module mgc_checker #(
    parameter int unsigned TBW = 24
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic [TBW-1:0] timebase,
    input logic           thread_me,
    input logic           tst_dis,
    input logic [TBW-1:0] mv0,
    input logic [TBW-1:0] mv1,
    input logic [1:0]     mode_v,
    input logic [2:0]     cfg0,
    input logic [2:0]     cfg1,
    input logic [1:0]     clr_v,
    input logic [1:0]     flag_v,
    input logic [1:0]     strobe_v
);
    for (genvar ch = 0; ch < 2; ch++) begin : g_chk
        logic [TBW-1:0] mv;
        logic [2:0]     cfg;
        logic           hit;

        always_comb begin
            mv  = (ch == 0) ? mv0 : mv1;
            cfg = (ch == 0) ? cfg0 : cfg1;
            hit = mode_v[ch] ? (timebase >= mv) : (timebase == mv);
        end

        a_r1_reset_clear: assert property (@(posedge clk)
            rst |=> (!flag_v[ch] && !strobe_v[ch]));

        a_r2_strobe_marks_rise: assert property (@(posedge clk) disable iff (rst)
            strobe_v[ch] |-> (flag_v[ch] && !$past(flag_v[ch])));

        a_r4_no_set_off_tick: assert property (@(posedge clk) disable iff (rst)
            (!tick && !flag_v[ch]) |=> !flag_v[ch]);

        a_r5_r6_blocked: assert property (@(posedge clk) disable iff (rst)
            (tick && !cfg[2] && (!thread_me || tst_dis) && !flag_v[ch]) |=> !flag_v[ch]);

        a_r7_override_open: assert property (@(posedge clk) disable iff (rst)
            (tick && cfg[2] && hit && !clr_v[ch]) |=> flag_v[ch]);

        a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
            (flag_v[ch] && !clr_v[ch]) |=> (flag_v[ch] && !strobe_v[ch]));

        a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
            clr_v[ch] |=> (!flag_v[ch] && !strobe_v[ch]));
    end
endmodule

bind match_gate_cmp mgc_checker #(.TBW(TBW)) u_mgc_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .timebase  (timebase),
    .thread_me (thread_me),
    .tst_dis   (tst_dis),
    .mv0       (match_a),
    .mv1       (match_b),
    .mode_v    ({mode_b, mode_a}),
    .cfg0      (pin_cfg_a),
    .cfg1      (pin_cfg_b),
    .clr_v     ({clr_b, clr_a}),
    .flag_v    ({flag_b, flag_a}),
    .strobe_v  ({strobe_b, strobe_a})
);

// File: tb/match_gate_cmp_bench.sv
module match_gate_cmp_bench;
    localparam int TBW = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick = 1'b0;
    logic [TBW-1:0] timebase = '0;
    logic           thread_me = 1'b0;
    logic           tst_dis = 1'b0;
    logic [TBW-1:0] match_a = '0;
    logic           mode_a = 1'b0;
    logic [2:0]     pin_cfg_a = 3'd0;
    logic           clr_a = 1'b0;
    logic [TBW-1:0] match_b = '0;
    logic           mode_b = 1'b0;
    logic [2:0]     pin_cfg_b = 3'd0;
    logic           clr_b = 1'b0;
    logic           flag_a, strobe_a, flag_b, strobe_b;

    int checks = 0;
    int errors = 0;
    logic exp_fa = 1'b0, exp_sa = 1'b0, exp_fb = 1'b0, exp_sb = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    match_gate_cmp #(.TBW(TBW)) u_match_gate_cmp (
        .clk(clk), .rst(rst), .tick(tick), .timebase(timebase),
        .thread_me(thread_me), .tst_dis(tst_dis),
        .match_a(match_a), .mode_a(mode_a), .pin_cfg_a(pin_cfg_a), .clr_a(clr_a),
        .match_b(match_b), .mode_b(mode_b), .pin_cfg_b(pin_cfg_b), .clr_b(clr_b),
        .flag_a(flag_a), .strobe_a(strobe_a), .flag_b(flag_b), .strobe_b(strobe_b)
    );

    function automatic logic [1:0] model(input logic f, input logic clr,
                                         input logic md, input logic [2:0] cfg,
                                         input logic [TBW-1:0] mv);
        logic open, hit, rec;
        open = cfg[2] || (thread_me && !tst_dis);
        hit  = md ? (timebase >= mv) : (timebase == mv);
        rec  = tick && open && hit && !f;
        if (rst || clr) return 2'b00;
        return {f | rec, rec};
    endfunction

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        logic [1:0] na, nb;
        na = model(exp_fa, clr_a, mode_a, pin_cfg_a, match_a);
        nb = model(exp_fb, clr_b, mode_b, pin_cfg_b, match_b);
        @(posedge clk);
        {exp_fa, exp_sa} = na;
        {exp_fb, exp_sb} = nb;
        @(negedge clk);
        chk("flag_a", flag_a, exp_fa);
        chk("strobe_a", strobe_a, exp_sa);
        chk("flag_b", flag_b, exp_fb);
        chk("strobe_b", strobe_b, exp_sb);
    endtask

    task automatic clear_all();
        clr_a = 1'b1; clr_b = 1'b1; cyc();
        clr_a = 1'b0; clr_b = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        @(negedge clk);
        tag = "R1";
        tick = 1'b1; thread_me = 1'b1;
        match_a = 24'd5; match_b = 24'd5;
        cyc(); cyc();
        rst = 1'b0;
        timebase = 24'd0;
        cyc();

        tag = "R2"; // equal-only hit, A only: also R12 independence
        match_a = 24'd100; match_b = 24'd200; mode_a = 1'b0; mode_b = 1'b0;
        timebase = 24'd99;  cyc();
        timebase = 24'd100; cyc();
        chk("R2 flag_a set", flag_a, 1'b1);
        chk("R12 flag_b untouched", flag_b, 1'b0);
        timebase = 24'd101; cyc();
        chk("R2 strobe one clock", strobe_a, 1'b0);

        tag = "R10";
        timebase = 24'd100; cyc(); cyc();
        chk("R10 held", flag_a, 1'b1);
        clear_all();

        tag = "R3";
        mode_a = 1'b1; match_a = 24'hFFFF00;
        timebase = 24'h00FFFF; cyc();
        chk("R3 below unsigned", flag_a, 1'b0);
        timebase = 24'hFFFF10; cyc();
        chk("R3 above", flag_a, 1'b1);
        clear_all();

        tag = "R4";
        mode_a = 1'b0; match_a = 24'd50; timebase = 24'd50; tick = 1'b0;
        cyc(); cyc();
        chk("R4 no tick", flag_a, 1'b0);
        tick = 1'b1;

        tag = "R8";
        tst_dis = 1'b1; cyc();
        chk("R6 dis blocks", flag_a, 1'b0);
        tst_dis = 1'b0; timebase = 24'd51; cyc();
        chk("R8 eq lost", flag_a, 1'b0);

        tag = "R9";
        mode_a = 1'b1; thread_me = 1'b0; timebase = 24'd50; cyc();
        chk("R5 me low blocks", flag_a, 1'b0);
        timebase = 24'd55; cyc();
        thread_me = 1'b1; timebase = 24'd60; cyc();
        chk("R9 late ge", flag_a, 1'b1);
        clear_all();

        tag = "R7";
        mode_a = 1'b0; pin_cfg_a = 3'b111; thread_me = 1'b0; tst_dis = 1'b1;
        timebase = 24'd50; cyc();
        chk("R7 override", flag_a, 1'b1);
        pin_cfg_b = 3'b011; mode_b = 1'b1; match_b = 24'd10; cyc();
        chk("R7 low bits no override", flag_b, 1'b0);
        clear_all();

        tag = "R11";
        thread_me = 1'b1; tst_dis = 1'b0; clr_a = 1'b1; cyc();
        chk("R11 clear wins", flag_a, 1'b0);
        chk("R11 no strobe", strobe_a, 1'b0);
        clr_a = 1'b0;

        tag = "R12";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            tick      = (r[3:0] != 4'd0);
            thread_me = (r[6:4] != 3'd0);
            tst_dis   = (r[9:7] == 3'd0);
            clr_a     = (r[14:10] == 5'd0);
            clr_b     = (r[19:15] == 5'd0);
            if (r[24:20] == 5'd0) begin
                mode_a = $urandom_range(0, 1); pin_cfg_a = 3'($urandom_range(0, 7));
                mode_b = $urandom_range(0, 1); pin_cfg_b = 3'($urandom_range(0, 7));
                match_a = 24'($urandom_range(0, 40));
                match_b = 24'($urandom_range(0, 40));
            end
            if (r[26:25] == 2'd0) timebase = timebase + 24'd1;
            if (r[31:27] == 5'd0) timebase = 24'($urandom_range(0, 40));
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule